// File: doc/BRIEF.md
# Hardwired-Control Accumulator Processor

A compact 12-bit processor built around an accumulator, with a control unit made of plain gates rather than a control store. A timing-state counter steps through states T1 to T6. Every datapath control line (register load enables, bus drive enables, ALU subtract select, memory strobes) is a sum of products of one timing state and one decoded opcode. The datapath holds a program counter, an instruction register, a memory address register, a memory data register, the accumulator AC, an operand register B, two general-purpose registers D and E, and an adder/subtractor. All of them share one internal bus.

The core talks to a single synchronous memory. The memory takes an address, a read strobe and a write strobe at a clock edge, and it returns read data in the following cycle. Each instruction first fetches its word in three states, then runs one to three execute states, and the counter then goes back to T1. The instruction set has the seven accumulator instructions plus four instructions that move data to and from D and E.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the core presents a fetch: mem_rd is 1, mem_addr is 0 and mem_wr is 0. All registers and the timing counter start cleared.
- R2: Every instruction fetches in T1 to T3. A read at the address held in PC takes place in T1, and PC increments in T2. The instruction length counts from T1: 6 cycles for LDA and LDE, 5 for STA, and 4 for every other opcode.
- R3: The instruction word carries the opcode in bits 11:8 and the address in bits 7:0. The opcodes are LDA=0, STA=1, ADD=2, SUB=3, MBA=4, JMP=5, JN=6, MAD=7, MDA=8, MBE=9, LDE=10. Arbitrary programs built from these opcodes give the same memory writes as a sequential model of the instruction set.
- R4: mem_wr is high for exactly one cycle per STA, in its fifth state. During that cycle mem_addr equals the instruction's address field and mem_wdata equals AC.
- R5: LDA loads AC, and LDE loads E, from memory at the address field. The read strobe is issued in T4.
- R6: ADD sets AC to AC+B and SUB sets AC to AC-B, both modulo 4096.
- R7: MBA copies AC into B, MAD copies D into AC, MDA copies AC into D, and MBE copies E into B.
- R8: JMP loads PC with the address field. JN does the same only when bit 11 of AC is 1; otherwise execution continues with the next word.
- R9: Opcodes 11 to 15 change no register and no memory, and they take 4 cycles.
- R10: mem_rd is high only in T1 and in T4 of LDA or LDE, and never in the same cycle as mem_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the caller releases it synchronously |
| mem_addr | output | 8 | Memory address, valid with either strobe |
| mem_wdata | output | 12 | Write data (the accumulator) |
| mem_rdata | input | 12 | Read data, valid the cycle after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The bench goes after the sums of modulo-4096 arithmetic at both ends. A core that kept a carry or a borrow would store 0x1000-style values truncated wrongly, or store a wrong low word. JN is run with AC just negative and just positive. A sign test taken from the wrong bit, or an inverted sign test, would store a value from the skipped path. Every write is checked against the cycle in which it was expected. A state counter that ended an instruction one state early or late would move every later write. Unused opcodes sit between loads and stores. If any of them drove a load enable, the stored value would change, and the reads would be counted against the expected number.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W = 12;
  localparam int ADDR_W = 8;
  localparam int OPC_W  = DATA_W - ADDR_W;

  typedef enum logic [2:0] {
    ST_T1 = 3'd0,
    ST_T2 = 3'd1,
    ST_T3 = 3'd2,
    ST_T4 = 3'd3,
    ST_T5 = 3'd4,
    ST_T6 = 3'd5
  } tstate_e;

  localparam logic [OPC_W-1:0] OP_LDA = 4'd0;
  localparam logic [OPC_W-1:0] OP_STA = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADD = 4'd2;
  localparam logic [OPC_W-1:0] OP_SUB = 4'd3;
  localparam logic [OPC_W-1:0] OP_MBA = 4'd4;
  localparam logic [OPC_W-1:0] OP_JMP = 4'd5;
  localparam logic [OPC_W-1:0] OP_JN  = 4'd6;
  localparam logic [OPC_W-1:0] OP_MAD = 4'd7;
  localparam logic [OPC_W-1:0] OP_MDA = 4'd8;
  localparam logic [OPC_W-1:0] OP_MBE = 4'd9;
  localparam logic [OPC_W-1:0] OP_LDE = 4'd10;

  // bus drivers, register loads, memory strobes and end-of-instruction
  typedef struct packed {
    logic pc_oe;
    logic ir_oe;
    logic mdr_oe;
    logic ac_oe;
    logic d_oe;
    logic e_oe;
    logic alu_oe;
    logic mar_ld;
    logic mdr_ld;
    logic ir_ld;
    logic pc_ld;
    logic pc_inc;
    logic ac_ld;
    logic b_ld;
    logic d_ld;
    logic e_ld;
    logic alu_sub;
    logic mem_rd;
    logic mem_wr;
    logic last;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_timing.sv
module acc_cpu_timing
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    last,
  output tstate_e state
);

  tstate_e state_nx;

  always_comb begin
    if (last) begin
      state_nx = ST_T1;
    end else begin
      case (state)
        ST_T1:   state_nx = ST_T2;
        ST_T2:   state_nx = ST_T3;
        ST_T3:   state_nx = ST_T4;
        ST_T4:   state_nx = ST_T5;
        ST_T5:   state_nx = ST_T6;
        default: state_nx = ST_T1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_T1;
    else        state <= state_nx;
  end

endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int OW = 4
)(
  input  tstate_e       state,
  input  logic [OW-1:0] opcode,
  input  logic          ac_neg,
  output ctl_t          ctl
);

  logic t1, t2, t3, t4, t5, t6;
  logic i_lda, i_sta, i_add, i_sub, i_mba, i_jmp, i_jn;
  logic i_mad, i_mda, i_mbe, i_lde;

  always_comb begin
    t1 = (state == ST_T1);
    t2 = (state == ST_T2);
    t3 = (state == ST_T3);
    t4 = (state == ST_T4);
    t5 = (state == ST_T5);
    t6 = (state == ST_T6);
    i_lda = (opcode == OP_LDA);
    i_sta = (opcode == OP_STA);
    i_add = (opcode == OP_ADD);
    i_sub = (opcode == OP_SUB);
    i_mba = (opcode == OP_MBA);
    i_jmp = (opcode == OP_JMP);
    i_jn  = (opcode == OP_JN);
    i_mad = (opcode == OP_MAD);
    i_mda = (opcode == OP_MDA);
    i_mbe = (opcode == OP_MBE);
    i_lde = (opcode == OP_LDE);
  end

  // each line: OR of state-and-opcode product terms
  always_comb begin
    ctl.pc_oe   = t1;
    ctl.mar_ld  = t1 | (t4 & (i_lda | i_sta | i_lde));
    ctl.mem_rd  = t1 | (t4 & (i_lda | i_lde));
    ctl.mdr_ld  = t2 | (t5 & (i_lda | i_lde));
    ctl.pc_inc  = t2;
    ctl.mdr_oe  = t3 | (t6 & (i_lda | i_lde));
    ctl.ir_ld   = t3;
    ctl.ir_oe   = t4 & (i_lda | i_sta | i_lde | i_jmp | (i_jn & ac_neg));
    ctl.pc_ld   = t4 & (i_jmp | (i_jn & ac_neg));
    ctl.alu_oe  = t4 & (i_add | i_sub);
    ctl.alu_sub = t4 & i_sub;
    ctl.ac_ld   = (t4 & (i_add | i_sub | i_mad)) | (t6 & i_lda);
    ctl.ac_oe   = t4 & (i_mba | i_mda);
    ctl.b_ld    = t4 & (i_mba | i_mbe);
    ctl.d_oe    = t4 & i_mad;
    ctl.d_ld    = t4 & i_mda;
    ctl.e_oe    = t4 & i_mbe;
    ctl.e_ld    = t6 & i_lde;
    ctl.mem_wr  = t5 & i_sta;
    ctl.last    = (t4 & ~(i_lda | i_sta | i_lde)) | (t5 & i_sta) | t6;
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 12
)(
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          sub,
  output logic [DW-1:0] res
);

  logic [DW-1:0] opb_x;

  always_comb begin
    opb_x = sub ? ~opb : opb;
    res   = opa + opb_x + {{(DW-1){1'b0}}, sub};
  end

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] ir_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam int PADW = DW - AW;

  logic [AW-1:0] mar_q, pc_nx, mar_nx;
  logic [DW-1:0] mdr_q, b_q, d_q, e_q;
  logic [DW-1:0] mdr_nx, ir_nx, ac_nx, b_nx, d_nx, e_nx;
  logic [DW-1:0] bus, alu_y;

  acc_cpu_alu #(.DW(DW)) u_alu (
    .opa (ac_q),
    .opb (b_q),
    .sub (ctl.alu_sub),
    .res (alu_y)
  );

  // AND-OR bus: decode drives at most one source per state
  always_comb begin
    bus = ({DW{ctl.pc_oe}}  & {{PADW{1'b0}}, pc_q})
        | ({DW{ctl.ir_oe}}  & {{PADW{1'b0}}, ir_q[AW-1:0]})
        | ({DW{ctl.mdr_oe}} & mdr_q)
        | ({DW{ctl.ac_oe}}  & ac_q)
        | ({DW{ctl.d_oe}}   & d_q)
        | ({DW{ctl.e_oe}}   & e_q)
        | ({DW{ctl.alu_oe}} & alu_y);
  end

  always_comb begin
    pc_nx  = ctl.pc_ld  ? bus[AW-1:0] : (ctl.pc_inc ? pc_q + 1'b1 : pc_q);
    mar_nx = ctl.mar_ld ? bus[AW-1:0] : mar_q;
    mdr_nx = ctl.mdr_ld ? mem_rdata   : mdr_q;
    ir_nx  = ctl.ir_ld  ? bus         : ir_q;
    ac_nx  = ctl.ac_ld  ? bus         : ac_q;
    b_nx   = ctl.b_ld   ? bus         : b_q;
    d_nx   = ctl.d_ld   ? bus         : d_q;
    e_nx   = ctl.e_ld   ? bus         : e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
      b_q   <= '0;
      d_q   <= '0;
      e_q   <= '0;
    end else begin
      pc_q  <= pc_nx;
      mar_q <= mar_nx;
      mdr_q <= mdr_nx;
      ir_q  <= ir_nx;
      ac_q  <= ac_nx;
      b_q   <= b_nx;
      d_q   <= d_nx;
      e_q   <= e_nx;
    end
  end

  // memory sees the address in the same cycle it enters MAR
  always_comb begin
    mem_addr  = ctl.mar_ld ? bus[AW-1:0] : mar_q;
    mem_wdata = ac_q;
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
)(
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);

  localparam int OW = DW - AW;

  tstate_e       state;
  ctl_t          ctl;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ac_q;
  logic [DW-1:0] ir_q;
  logic [OW-1:0] opcode;

  assign opcode = ir_q[DW-1:AW];

  acc_cpu_timing u_timing (
    .clk   (clk),
    .rst_n (rst_n),
    .last  (ctl.last),
    .state (state)
  );

  acc_cpu_decode #(.OW(OW)) u_decode (
    .state  (state),
    .opcode (opcode),
    .ac_neg (ac_q[DW-1]),
    .ctl    (ctl)
  );

  acc_cpu_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .pc_q      (pc_q),
    .ac_q      (ac_q),
    .ir_q      (ir_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign mem_rd = ctl.mem_rd;
  assign mem_wr = ctl.mem_wr;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input tstate_e       state,
  input logic [DW-AW-1:0] opcode,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ac,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr
);

  a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1) |-> (mem_rd && mem_addr == pc));

  a_r2_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1) |=> (state == ST_T2));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2) |=> (pc == $past(pc) + 1'b1));

  a_r10_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_wr_ends_instr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (state == ST_T1));

  a_r8_jn_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T4 && opcode == OP_JN && !ac[DW-1]) |=> (pc == $past(pc)));

endmodule

bind acc_cpu_core acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .opcode   (opcode),
  .pc       (pc_q),
  .ac       (ac_q),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  localparam int DW   = 12;
  localparam int AW   = 8;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd, mem_wr;

  logic [DW-1:0] ram [MEMN];
  logic [DW-1:0] img [MEMN];

  int n_chk = 0;
  int n_err = 0;

  int exp_cyc[$];
  int exp_adr[$];
  int exp_dat[$];
  int exp_reads;

  always #2 clk = ~clk;

  acc_cpu_core i_acc_cpu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(int op, int a);
    return DW'((op << AW) | (a & (MEMN - 1)));
  endfunction

  function automatic int instr_len(int op);
    if (op == 0 || op == 10) return 6;
    if (op == 1) return 5;
    return 4;
  endfunction

  // sequential model of the instruction set
  task automatic model(int budget);
    logic [DW-1:0] m [MEMN];
    int pc, ac, b, d, e, t, op, a, len;
    m = img;
    pc = 0; ac = 0; b = 0; d = 0; e = 0; t = 0;
    exp_cyc.delete(); exp_adr.delete(); exp_dat.delete();
    exp_reads = 0;
    while (t < budget) begin
      op  = int'(m[pc][DW-1:AW]);
      a   = int'(m[pc][AW-1:0]);
      len = instr_len(op);
      exp_reads++;
      if ((op == 0 || op == 10) && t + 3 < budget) exp_reads++;
      if (t + len > budget) begin
        if (op == 1 && t + 4 < budget) begin
          exp_cyc.push_back(t + 4); exp_adr.push_back(a); exp_dat.push_back(ac);
        end
        break;
      end
      pc = (pc + 1) % MEMN;
      case (op)
        0:  ac = int'(m[a]);
        1:  begin
              m[a] = DW'(ac);
              exp_cyc.push_back(t + 4); exp_adr.push_back(a); exp_dat.push_back(ac);
            end
        2:  ac = (ac + b) % 4096;
        3:  ac = (ac - b + 4096) % 4096;
        4:  b = ac;
        5:  pc = a;
        6:  if (ac >= 2048) pc = a;
        7:  ac = d;
        8:  d = ac;
        9:  b = e;
        10: e = int'(m[a]);
        default: ;
      endcase
      t += len;
    end
  endtask

  task automatic run(string tag, int budget, bit chk_reset);
    int wi, reads, clash;
    model(budget);
    ram = img;
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    if (chk_reset) begin
      check("R1", "rd in reset", int'(mem_rd), 1);
      check("R1", "wr in reset", int'(mem_wr), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    wi = 0; reads = 0; clash = 0;
    for (int k = 0; k < budget; k++) begin
      #1;
      if (k == 0 && chk_reset) begin
        check("R1", "first rd", int'(mem_rd), 1);
        check("R1", "first addr", int'(mem_addr), 0);
        check("R1", "first wr", int'(mem_wr), 0);
      end
      if (mem_rd) reads++;
      if (mem_rd && mem_wr) clash++;
      if (mem_wr) begin
        if (wi < exp_cyc.size()) begin
          check("R2", "write cycle", k, exp_cyc[wi]);
          check("R4", "write addr", int'(mem_addr), exp_adr[wi]);
          check(tag, "write data", int'(mem_wdata), exp_dat[wi]);
        end else begin
          check("R4", "unexpected write", wi, exp_cyc.size());
        end
        wi++;
      end
      @(negedge clk);
    end
    check("R4", "write count", wi, exp_cyc.size());
    check("R10", "read count", reads, exp_reads);
    check("R10", "rd with wr", clash, 0);
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMN; i++) img[i] = '0;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2011);

    // R6: wrap of ADD and SUB
    clear_img();
    img[0] = enc(0, 8'h81); img[1] = enc(4, 0);     img[2] = enc(0, 8'h80);
    img[3] = enc(2, 0);     img[4] = enc(1, 8'h90); img[5] = enc(0, 8'h82);
    img[6] = enc(3, 0);     img[7] = enc(1, 8'h91); img[8] = enc(5, 8);
    img[8'h80] = 12'hFFF; img[8'h81] = 12'h001; img[8'h82] = 12'h000;
    run("R6", 80, 1'b1);

    // R5, R7: loads and register moves
    clear_img();
    img[0] = enc(0, 8'h80); img[1] = enc(8, 0);     img[2] = enc(0, 8'h81);
    img[3] = enc(7, 0);     img[4] = enc(1, 8'h90); img[5] = enc(10, 8'h82);
    img[6] = enc(9, 0);     img[7] = enc(0, 8'h83); img[8] = enc(2, 0);
    img[9] = enc(1, 8'h91); img[10] = enc(5, 10);
    img[8'h80] = 12'h5A5; img[8'h81] = 12'h0F0; img[8'h82] = 12'h123; img[8'h83] = 12'h700;
    run("R7", 100, 1'b0);
    run("R5", 100, 1'b0);

    // R8: JN taken at 0x800, not taken at 0x7FF, then JMP
    clear_img();
    img[0] = enc(0, 8'h80); img[1] = enc(6, 4);     img[2] = enc(1, 8'h90);
    img[3] = enc(5, 3);     img[4] = enc(0, 8'h81); img[5] = enc(6, 9);
    img[6] = enc(1, 8'h91); img[7] = enc(5, 10);    img[8] = enc(1, 8'h92);
    img[9] = enc(1, 8'h93); img[10] = enc(5, 10);
    img[8'h80] = 12'h800; img[8'h81] = 12'h7FF;
    run("R8", 100, 1'b0);

    // R9: unused opcodes between load and store
    clear_img();
    img[0] = enc(0, 8'h80); img[1] = enc(11, 8'h80); img[2] = enc(12, 8'h90);
    img[3] = enc(13, 8'hFF); img[4] = enc(14, 1);    img[5] = enc(15, 0);
    img[6] = enc(1, 8'h90); img[7] = enc(5, 7);
    img[8'h80] = 12'h9C3; img[8'h90] = 12'h111;
    run("R9", 80, 1'b0);

    // R3: random programs checked against the model
    for (int p = 0; p < 10; p++) begin
      for (int i = 0; i < MEMN; i++) img[i] = DW'($urandom_range(0, 4095));
      for (int i = 0; i < 48; i++) begin
        int op;
        op = $urandom_range(0, 15);
        if (op == 5 || op == 6) img[i] = enc(op, $urandom_range(0, 47));
        else                    img[i] = enc(op, $urandom_range(64, 255));
      end
      for (int i = 48; i < 64; i++) img[i] = enc(5, 48);
      run("R3", 400, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule